// File: doc/BRIEF.md
# Single-Wire Register Readback Transmitter

This block returns one byte of register content to a host over a shared, bidirectional single-wire data line. A command decoder elsewhere raises a one-cycle read request together with a 4-bit read pointer. The block captures the byte that the pointer selects and the bit period, measured in system clocks, that applies to this transfer. It then runs a fixed frame on the line through a data output and an output enable. The line has an external weak pull-up, so whenever the block is not driving, the pull-up holds the line high.

The frame is timed in bit periods:
- The block first leaves the line undriven for one byte time (ten bit periods). This gives the host time to tri-state its own driver.
- It then drives the line high for one bit period as a preamble.
- It sends a low start bit, the eight data bits least significant first, and a high stop bit.
- It releases the line straight after the stop bit.
- One more byte time later it reports that it is ready for the next command.

Read requests that arrive while a frame is in progress are ignored.

Top module: `swire_readback_tx`

## Requirements
- R1: After reset, `ready` is 1, `line_oe` is 0 and `line_out` is 1.
- R2: A `rd_req` pulse seen at a clock edge while `ready` is 1 is accepted, and `ready` is 0 from the next cycle. A `rd_req` seen while `ready` is 0 is ignored: it does not change the waveform or the returned byte of the running transfer.
- R3: For the first 10 bit periods after acceptance, `line_oe` is 0.
- R4: In bit period 10, the block drives `line_out` high with `line_oe`=1. In bit period 11, it drives the start bit low.
- R5: Bit periods 12 to 19 carry data bits 0 to 7 (LSB first). Bit period 20 is a high stop bit. `line_oe` returns to 0 in the first cycle after the stop bit.
- R6: `ready` returns to 1 exactly 10 bit periods after the release, which is 31 bit periods after acceptance. `line_oe` stays 0 during those 10 periods.
- R7: Pointer 4'h0 returns `hold_reg[7:0]`. Pointer 4'h1 returns `hold_reg[15:8]`.
- R8: Pointer 4'h2 returns {`ee_addr[7:4]`, `cal_addr`}. Pointer 4'h3 returns {`cmd_nib`, 4'h3}. Pointer 4'h4 returns {`aloc`, `atim`}.
- R9: Pointers 4'h5 to 4'h8 return `ee_addr`, `ee_data`, `temp_idx` and `bitclk_cnt`, in that order. Pointer 4'h9 returns the fixed pattern 8'hCA. Pointers 4'hA to 4'hF return 8'h00.
- R10: One bit period lasts `bit_len` clocks, sampled at acceptance. A `bit_len` of 0 is treated as 1.
- R11: The returned byte and the bit period are captured at acceptance. Input changes after that point do not alter the running frame.
- R12: Whenever `line_oe` is 0, `line_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request pulse |
| rd_ptr | input | 4 | Readback pointer |
| bit_len | input | 16 | Bit period in clocks |
| hold_reg | input | 16 | Data-hold register |
| ee_addr | input | 8 | EEPROM address low byte |
| ee_data | input | 8 | EEPROM data byte |
| cal_addr | input | 4 | Calibration register address nibble |
| cmd_nib | input | 4 | Command nibble |
| aloc | input | 4 | Analog location nibble |
| atim | input | 4 | Analog timeout nibble |
| temp_idx | input | 8 | Temperature index byte |
| bitclk_cnt | input | 8 | Bit-clock count byte |
| line_out | output | 1 | Value driven onto the line |
| line_oe | output | 1 | Line output enable |
| ready | output | 1 | Ready for the next command |

## Verification
All sixteen pointer values are swept with a one-clock bit period. The line is compared in every cycle against a frame model built from slot arithmetic. This separates the packed-nibble entries, the fixed-pattern entry, the reserved entries and the plain byte entries, and any error in data bit order shows up at once. The same frame is repeated with bit periods of 0, 2 and 3 clocks. This exposes off-by-one faults in the bit timer and shows whether a zero length is clamped. Further frames inject an extra request and change every source register mid-transfer, which tells a correct capture apart from a live mux or a restart. Back-to-back requests check that the block accepts a new command in the first cycle after `ready` returns.

// File: rtl/swrb_pkg.sv
package swrb_pkg;

  typedef enum logic [2:0] {
    PH_GAP, PH_PRE, PH_START, PH_DATA, PH_STOP, PH_REL
  } phase_e;

  // map a bit-slot index to its frame phase
  function automatic phase_e slot_phase(input int unsigned slot,
                                        input int unsigned gap,
                                        input int unsigned dw);
    if (slot < gap)                 return PH_GAP;
    else if (slot == gap)           return PH_PRE;
    else if (slot == gap + 1)       return PH_START;
    else if (slot < gap + 2 + dw)   return PH_DATA;
    else if (slot == gap + 2 + dw)  return PH_STOP;
    else                            return PH_REL;
  endfunction

  // clocks-per-bit minus one, with zero clamped to one clock
  function automatic logic [15:0] bit_limit(input logic [15:0] len);
    return (len == 16'd0) ? 16'd0 : len - 16'd1;
  endfunction

endpackage

// File: rtl/swrb_sel_mux.sv
module swrb_sel_mux (
  input  logic [3:0]  ptr,
  input  logic [15:0] hold_reg,
  input  logic [7:0]  ee_addr,
  input  logic [7:0]  ee_data,
  input  logic [3:0]  cal_addr,
  input  logic [3:0]  cmd_nib,
  input  logic [3:0]  aloc,
  input  logic [3:0]  atim,
  input  logic [7:0]  temp_idx,
  input  logic [7:0]  bitclk_cnt,
  output logic [7:0]  sel_byte
);
  localparam logic [7:0] COMM_PATTERN = 8'hCA;

  always_comb begin
    unique case (ptr)
      4'h0:    sel_byte = hold_reg[7:0];
      4'h1:    sel_byte = hold_reg[15:8];
      4'h2:    sel_byte = {ee_addr[7:4], cal_addr};
      4'h3:    sel_byte = {cmd_nib, ptr};
      4'h4:    sel_byte = {aloc, atim};
      4'h5:    sel_byte = ee_addr;
      4'h6:    sel_byte = ee_data;
      4'h7:    sel_byte = temp_idx;
      4'h8:    sel_byte = bitclk_cnt;
      4'h9:    sel_byte = COMM_PATTERN;
      default: sel_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/swrb_bit_timer.sv
module swrb_bit_timer #(
  parameter int BLW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  input  logic [BLW-1:0] lim,
  output logic           bit_end
);
  logic [BLW-1:0] cnt;

  assign bit_end = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (bit_end) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  // R10
  cnt_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= lim);
endmodule

// File: rtl/swrb_frame_seq.sv
module swrb_frame_seq
  import swrb_pkg::*;
#(
  parameter int GAP_BITS = 10,
  parameter int DATA_W   = 8,
  parameter int SLOT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bit_end,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              line_out,
  output logic              line_oe
);
  localparam int DATA0     = GAP_BITS + 2;
  localparam int LAST_SLOT = DATA0 + DATA_W + GAP_BITS;
  localparam int BIT_IW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [SLOT_W-1:0] slot;
  phase_e            phase;
  logic [BIT_IW-1:0] bit_idx;
  logic              last_slot;

  assign phase     = slot_phase(32'(slot), GAP_BITS, DATA_W);
  assign bit_idx   = BIT_IW'(32'(slot) - DATA0);
  assign last_slot = (32'(slot) == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        slot <= '0;
      end
    end else if (bit_end) begin
      if (last_slot) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_comb begin
    line_oe  = 1'b0;
    line_out = 1'b1;
    if (busy) begin
      unique case (phase)
        PH_PRE:   begin line_oe = 1'b1; line_out = 1'b1; end
        PH_START: begin line_oe = 1'b1; line_out = 1'b0; end
        PH_DATA:  begin line_oe = 1'b1; line_out = tx_byte[bit_idx]; end
        PH_STOP:  begin line_oe = 1'b1; line_out = 1'b1; end
        default:  begin line_oe = 1'b0; line_out = 1'b1; end
      endcase
    end
  end

  // R4
  preamble_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> line_out);
  // R5
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> $past(line_out));
  // R3
  no_drive_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !line_oe);
endmodule

// File: rtl/swire_readback_tx.sv
module swire_readback_tx
  import swrb_pkg::*;
#(
  parameter int GAP_BITS = 10,
  parameter int BLW      = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_req,
  input  logic [3:0]     rd_ptr,
  input  logic [BLW-1:0] bit_len,
  input  logic [15:0]    hold_reg,
  input  logic [7:0]     ee_addr,
  input  logic [7:0]     ee_data,
  input  logic [3:0]     cal_addr,
  input  logic [3:0]     cmd_nib,
  input  logic [3:0]     aloc,
  input  logic [3:0]     atim,
  input  logic [7:0]     temp_idx,
  input  logic [7:0]     bitclk_cnt,
  output logic           line_out,
  output logic           line_oe,
  output logic           ready
);
  localparam int DATA_W = 8;
  localparam int SLOTS  = GAP_BITS + 2 + DATA_W + GAP_BITS + 1;
  localparam int SLOT_W = $clog2(SLOTS);

  logic              busy, accept, bit_end;
  logic [DATA_W-1:0] sel_byte, tx_byte;
  logic [BLW-1:0]    lim;

  assign accept = rd_req && !busy;
  assign ready  = !busy;

  swrb_sel_mux u_mux (
    .ptr(rd_ptr), .hold_reg(hold_reg), .ee_addr(ee_addr), .ee_data(ee_data),
    .cal_addr(cal_addr), .cmd_nib(cmd_nib), .aloc(aloc), .atim(atim),
    .temp_idx(temp_idx), .bitclk_cnt(bitclk_cnt), .sel_byte(sel_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      lim     <= '0;
    end else if (accept) begin
      tx_byte <= sel_byte;
      lim     <= BLW'(bit_limit(16'(bit_len)));
    end
  end

  swrb_bit_timer #(.BLW(BLW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(accept), .run(busy), .lim(lim),
    .bit_end(bit_end)
  );

  swrb_frame_seq #(.GAP_BITS(GAP_BITS), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .bit_end(bit_end),
    .tx_byte(tx_byte), .busy(busy), .line_out(line_out), .line_oe(line_oe)
  );

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ready) |=> !ready);
  // R2
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !ready) |=> ($stable(tx_byte) && $stable(lim)));
  // R6
  no_drive_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !line_oe);
endmodule

// File: tb/swire_readback_tx_bench.sv
module swire_readback_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_ptr = '0;
  logic [15:0] bit_len = 16'd1;
  logic [15:0] hold_reg = 16'hA53C;
  logic [7:0]  ee_addr = 8'h6E, ee_data = 8'h91, temp_idx = 8'h2D, bitclk_cnt = 8'hF4;
  logic [3:0]  cal_addr = 4'h7, cmd_nib = 4'h5, aloc = 4'hB, atim = 4'h2;
  logic        line_out, line_oe, ready;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swire_readback_tx u_swire_readback_tx (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ptr(rd_ptr), .bit_len(bit_len),
    .hold_reg(hold_reg), .ee_addr(ee_addr), .ee_data(ee_data), .cal_addr(cal_addr),
    .cmd_nib(cmd_nib), .aloc(aloc), .atim(atim), .temp_idx(temp_idx),
    .bitclk_cnt(bitclk_cnt), .line_out(line_out), .line_oe(line_oe), .ready(ready)
  );

  function automatic logic [7:0] want_byte(input logic [3:0] p);
    logic [7:0] r;
    r = 8'h00;
    if (p == 4'd0)      r = hold_reg[7:0];
    else if (p == 4'd1) r = hold_reg[15:8];
    else if (p == 4'd2) r = (ee_addr & 8'hF0) | {4'h0, cal_addr};
    else if (p == 4'd3) r = {cmd_nib, 4'b0011};
    else if (p == 4'd4) r = {aloc, 4'h0} | {4'h0, atim};
    else if (p == 4'd5) r = ee_addr;
    else if (p == 4'd6) r = ee_data;
    else if (p == 4'd7) r = temp_idx;
    else if (p == 4'd8) r = bitclk_cnt;
    else if (p == 4'd9) r = 8'b1100_1010;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one full transfer, checked every cycle at the falling edge
  task automatic xfer(input logic [3:0] p, input int len, input string dtag,
                      input bit inj_req, input bit chg_src);
    logic [7:0] exp_b;
    int n, s, t;
    bit e_oe, e_out, e_rdy;
    string tag;
    n = (len == 0) ? 1 : len;
    exp_b = want_byte(p);
    check(ready === 1'b1, "R2", "ready before request", int'(ready), 1);
    rd_ptr = p; bit_len = 16'(len); rd_req = 1'b1;
    @(negedge clk);
    for (t = 0; t <= 31 * n; t++) begin
      s = t / n;
      e_rdy = (t == 31 * n);
      e_oe  = !e_rdy && (s >= 10) && (s <= 20);
      if (!e_oe)        e_out = 1'b1;
      else if (s == 10) e_out = 1'b1;
      else if (s == 11) e_out = 1'b0;
      else if (s <= 19) e_out = exp_b[s - 12];
      else              e_out = 1'b1;
      if (s < 10)       tag = "R3";
      else if (s < 12)  tag = "R4";
      else if (s < 20)  tag = dtag;
      else if (s == 20) tag = "R5";
      else              tag = "R6";
      if (len != 1) tag = {tag, "/R10"};
      if (inj_req || chg_src) tag = {tag, "/R11"};
      check(line_oe === e_oe, tag, $sformatf("oe t=%0d", t), int'(line_oe), int'(e_oe));
      check(line_out === e_out, tag, $sformatf("out t=%0d", t), int'(line_out), int'(e_out));
      check(ready === e_rdy, tag, $sformatf("ready t=%0d", t), int'(ready), int'(e_rdy));
      if (!line_oe) check(line_out === 1'b1, "R12", "idle level", int'(line_out), 1);
      rd_req = 1'b0;
      if (inj_req && t == 3) begin rd_req = 1'b1; rd_ptr = p ^ 4'h9; bit_len = 16'd5; end // R2
      if (chg_src && t == 2) begin
        hold_reg = ~hold_reg; ee_addr = ~ee_addr; ee_data = ~ee_data;
        temp_idx = temp_idx + 8'h33; bitclk_cnt = ~bitclk_cnt;
        cal_addr = ~cal_addr; cmd_nib = ~cmd_nib; aloc = ~aloc; atim = ~atim;
        bit_len = 16'd7;
      end
      if (t < 31 * n) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(ready === 1'b1, "R1", "reset ready", int'(ready), 1);
    check(line_oe === 1'b0, "R1", "reset oe", int'(line_oe), 0);
    check(line_out === 1'b1, "R1", "reset out", int'(line_out), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep every pointer: R7 R8 R9
    for (int p = 0; p < 16; p++) begin
      string dt;
      dt = (p < 2) ? "R7" : (p < 5) ? "R8" : "R9";
      xfer(4'(p), 1, dt, 1'b0, 1'b0);
    end
    xfer(4'h9, 0, "R9", 1'b0, 1'b0);   // R10 zero clamp
    xfer(4'h0, 2, "R7", 1'b0, 1'b0);
    xfer(4'h4, 3, "R8", 1'b0, 1'b0);
    xfer(4'h2, 2, "R8", 1'b1, 1'b0);   // R2 ignored request
    xfer(4'h6, 3, "R9", 1'b0, 1'b1);   // R11 source change
    xfer(4'h1, 1, "R7", 1'b1, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule